// File: doc/BRIEF.md
# Four-Channel DShot Frame Transmitter

This block drives four motor-controller lines with DShot frames in lock step. At a load strobe it takes one 16-bit command word per channel and turns it into a 16-bit frame. The frame holds an 11-bit throttle value, a telemetry-request flag and a 4-bit checksum. It then sends each frame as twenty pulse slots of equal length. The first sixteen slots carry the data bits, most significant first. A short high time encodes a 0 and a long high time encodes a 1. The last four slots never go active, which leaves the receiver an idle gap.

The slot length is given in clock cycles on a period input. It is clamped to a safe range and captured, together with the mode, when a load is accepted. In bidirectional mode the checksum is inverted and every line is inverted, so an idle line rests high. While a frame is in flight a plain load is refused. A load with the force input set drops the current frame and starts the new one at once.

Top module: `dshot_quad_tx`

## Requirements
- R1: The frame places command bits 10..0 (throttle) in frame bits 15..5 and command bit 15 (telemetry flag) in frame bit 4. Command bits 14..11 have no effect on the line output.
- R2: Frame bits 3..0 hold the XOR of the three nibbles of frame bits 15..4. This checksum is bit-inverted when bidirectional mode was set at load.
- R3: All channels start on the clock edge that accepts the load. Each data slot goes active in its first cycle. Frame bit 15 is sent in slot 0 and bit 0 in slot 15, one bit per period.
- R4: A slot carrying a 0 is active for floor(P*379/1024) cycles and a slot carrying a 1 for floor(P*767/1024) cycles, where P is the effective period. The slot is inactive for the rest of it.
- R5: A frame lasts exactly 20*P cycles. Slots 16..19 are fully inactive. busy_o is high for the whole frame and drops in the cycle after the last one.
- R6: The effective period is period_i clamped to the range from MIN_PERIOD (default 4) to CLK_HZ/MIN_RATE (default 833).
- R7: With bidirectional mode set the inactive level is 1 and the active level is 0. Otherwise the inactive level is 0. An idle line rests at the inactive level.
- R8: A load without force while busy_o is high is ignored. The current frame, its period and its polarity continue unchanged.
- R9: A load with force set is always accepted. It aborts any frame in flight and starts the new frame from slot 0 on that edge.
- R10: Mode and period are captured at the accepting edge. Later changes of bidir_i or period_i do not affect the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bidir_i | input | 1 | Bidirectional mode: inverted checksum and line polarity |
| period_i | input | PERIOD_W (16) | Requested slot length in clock cycles |
| load_i | input | 1 | Load strobe for all channel commands |
| force_i | input | 1 | Accept the load even while busy, aborting the current frame |
| cmd_i | input | NCH*16 (64) | Command words; channel n uses bits 16n+15..16n |
| busy_o | output | 1 | A frame is being sent |
| line_o | output | NCH (4) | Per-channel DShot line outputs |

## Verification
The bench sweeps command patterns across several periods and both polarities. It measures the active time of every slot on every channel. A design with off-by-one high times, slot lengths off by one, a reversed bit order or a wrong checksum nibble shows up as a slot with the wrong count. Commands with only bits 14..11 set show whether unused bits leak into the frame. Periods below and above the legal range show a missing clamp as a frame of the wrong length. A refused mid-frame load with changed mode and period would corrupt the slot counts if it were accepted. A forced reload that failed to restart from slot 0 would misalign the whole frame.

// File: rtl/dshot_quad_pkg.sv
package dshot_quad_pkg;
    localparam int CMD_W       = 16;
    localparam int FRAME_W     = 16;
    localparam int THR_W       = 11;
    localparam int CSUM_W      = 4;
    localparam int DATA_SLOTS  = FRAME_W;
    localparam int IDLE_SLOTS  = 4;
    localparam int TOTAL_SLOTS = DATA_SLOTS + IDLE_SLOTS;
    localparam int SLOT_W      = $clog2(TOTAL_SLOTS);
    localparam int BIT_IDX_W   = $clog2(FRAME_W);
    localparam int TEL_POS     = CMD_W - 1;
    // Pulse width fractions: numerator over 2**FRAC_SHIFT
    localparam int FRAC_SHIFT  = 10;
    localparam int ZERO_NUM    = 379;
    localparam int ONE_NUM     = 767;

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [SLOT_W-1:0]  slot_t;
endpackage

// File: rtl/dshot_frame_build.sv
module dshot_frame_build
    import dshot_quad_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             bidir_i,
    output frame_t           frame_o
);
    localparam int UPPER_W = FRAME_W - CSUM_W;
    localparam int NIBBLES = UPPER_W / CSUM_W;

    logic [UPPER_W-1:0] upper;
    logic [CSUM_W-1:0]  csum;

    always_comb begin
        upper = {cmd_i[THR_W-1:0], cmd_i[TEL_POS]};
        csum  = '0;
        for (int n = 0; n < NIBBLES; n++) begin
            csum = csum ^ upper[n*CSUM_W +: CSUM_W];
        end
        if (bidir_i) begin
            csum = ~csum;
        end
        frame_o = {upper, csum};
    end
endmodule

// File: rtl/dshot_slot_timer.sv
module dshot_slot_timer
    import dshot_quad_pkg::*;
#(
    parameter int PERIOD_W   = 16,
    parameter int CLK_HZ     = 125_000_000,
    parameter int MIN_RATE   = 150_000,
    parameter int MIN_PERIOD = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                load_i,
    input  logic                force_i,
    input  logic                bidir_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                start_o,
    output logic                busy_o,
    output logic                pol_o,
    output slot_t               slot_o,
    output logic [PERIOD_W-1:0] cnt_o,
    output logic [PERIOD_W-1:0] hi0_o,
    output logic [PERIOD_W-1:0] hi1_o
);
    localparam int PROD_W     = PERIOD_W + FRAC_SHIFT;
    localparam int MAX_PERIOD = CLK_HZ / MIN_RATE;
    localparam logic [PERIOD_W-1:0] MAX_P = PERIOD_W'(MAX_PERIOD);
    localparam logic [PERIOD_W-1:0] MIN_P = PERIOD_W'(MIN_PERIOD);
    localparam slot_t LAST_SLOT = slot_t'(TOTAL_SLOTS - 1);

    typedef struct packed {
        logic                busy;
        logic                pol;
        slot_t               slot;
        logic [PERIOD_W-1:0] cnt;
        logic [PERIOD_W-1:0] per;
        logic [PERIOD_W-1:0] hi0;
        logic [PERIOD_W-1:0] hi1;
    } tstate_t;

    tstate_t st_d, st_q;
    logic [PERIOD_W-1:0] per_clamp;
    logic [PROD_W-1:0]   prod0, prod1;
    logic                start;

    always_comb begin
        if (period_i < MIN_P) begin
            per_clamp = MIN_P;
        end else if (period_i > MAX_P) begin
            per_clamp = MAX_P;
        end else begin
            per_clamp = period_i;
        end
        prod0 = PROD_W'(per_clamp) * PROD_W'(ZERO_NUM);
        prod1 = PROD_W'(per_clamp) * PROD_W'(ONE_NUM);
        start = load_i & (~st_q.busy | force_i);

        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.pol  = bidir_i;
            st_d.slot = '0;
            st_d.cnt  = '0;
            st_d.per  = per_clamp;
            st_d.hi0  = prod0[PROD_W-1:FRAC_SHIFT];
            st_d.hi1  = prod1[PROD_W-1:FRAC_SHIFT];
        end else if (st_q.busy) begin
            if (st_q.cnt == (st_q.per - PERIOD_W'(1))) begin
                st_d.cnt = '0;
                if (st_q.slot == LAST_SLOT) begin
                    st_d.busy = 1'b0;
                    st_d.slot = '0;
                end else begin
                    st_d.slot = st_q.slot + slot_t'(1);
                end
            end else begin
                st_d.cnt = st_q.cnt + PERIOD_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o = start;
    assign busy_o  = st_q.busy;
    assign pol_o   = st_q.pol;
    assign slot_o  = st_q.slot;
    assign cnt_o   = st_q.cnt;
    assign hi0_o   = st_q.hi0;
    assign hi1_o   = st_q.hi1;

    // R5: counters stay inside the frame geometry while busy
    a_r5_slot_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.busy |-> (st_q.cnt < st_q.per) && (st_q.slot <= LAST_SLOT));

    // R6: captured period always lies in the legal range
    a_r6_period_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.busy |-> (st_q.per >= MIN_P) && (st_q.per <= MAX_P));

    // R8, R10: refused load leaves period and polarity untouched
    a_r8_refuse_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && load_i && !force_i) |=> ($stable(st_q.per) && $stable(st_q.pol)));

    // R9: forced load restarts at slot 0
    a_r9_force_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && force_i) |=> (st_q.busy && st_q.slot == '0 && st_q.cnt == '0));
endmodule

// File: rtl/dshot_pulse_gen.sv
module dshot_pulse_gen
    import dshot_quad_pkg::*;
#(
    parameter int PERIOD_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  frame_t              frame_i,
    input  logic                busy_i,
    input  logic                pol_i,
    input  slot_t               slot_i,
    input  logic [PERIOD_W-1:0] cnt_i,
    input  logic [PERIOD_W-1:0] hi0_i,
    input  logic [PERIOD_W-1:0] hi1_i,
    output logic                line_o
);
    typedef struct packed {
        frame_t frame;
    } pstate_t;

    pstate_t st_d, st_q;
    slot_t                 idx_full;
    logic [BIT_IDX_W-1:0]  idx;
    logic                  cur_bit;
    logic                  in_data;
    logic [PERIOD_W-1:0]   hi_sel;
    logic                  active;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.frame = frame_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        idx_full = slot_t'(FRAME_W - 1) - slot_i;
        idx      = idx_full[BIT_IDX_W-1:0];
        cur_bit  = st_q.frame[idx];
        in_data  = slot_i < slot_t'(DATA_SLOTS);
        hi_sel   = cur_bit ? hi1_i : hi0_i;
        active   = busy_i && in_data && (cnt_i < hi_sel);
        line_o   = active ^ pol_i;
    end

    // R3: every data slot opens at the active level
    a_r3_slot_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && in_data && cnt_i == '0) |-> (line_o != pol_i));

    // R5: trailing slots stay at the inactive level
    a_r5_tail_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && !in_data) |-> (line_o == pol_i));

    // R7: idle line rests at the inactive level
    a_r7_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_i |-> (line_o == pol_i));
endmodule

// File: rtl/dshot_quad_tx.sv
module dshot_quad_tx
    import dshot_quad_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int PERIOD_W   = 16,
    parameter int CLK_HZ     = 125_000_000,
    parameter int MIN_RATE   = 150_000,
    parameter int MIN_PERIOD = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  bidir_i,
    input  logic [PERIOD_W-1:0]   period_i,
    input  logic                  load_i,
    input  logic                  force_i,
    input  logic [NCH*CMD_W-1:0]  cmd_i,
    output logic                  busy_o,
    output logic [NCH-1:0]        line_o
);
    logic                start;
    logic                busy;
    logic                pol;
    slot_t               slot;
    logic [PERIOD_W-1:0] cnt;
    logic [PERIOD_W-1:0] hi0;
    logic [PERIOD_W-1:0] hi1;

    dshot_slot_timer #(
        .PERIOD_W   (PERIOD_W),
        .CLK_HZ     (CLK_HZ),
        .MIN_RATE   (MIN_RATE),
        .MIN_PERIOD (MIN_PERIOD)
    ) timer_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (load_i),
        .force_i  (force_i),
        .bidir_i  (bidir_i),
        .period_i (period_i),
        .start_o  (start),
        .busy_o   (busy),
        .pol_o    (pol),
        .slot_o   (slot),
        .cnt_o    (cnt),
        .hi0_o    (hi0),
        .hi1_o    (hi1)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        frame_t frame;

        dshot_frame_build build_i (
            .cmd_i   (cmd_i[ch*CMD_W +: CMD_W]),
            .bidir_i (bidir_i),
            .frame_o (frame)
        );

        dshot_pulse_gen #(
            .PERIOD_W (PERIOD_W)
        ) pulse_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .start_i (start),
            .frame_i (frame),
            .busy_i  (busy),
            .pol_i   (pol),
            .slot_i  (slot),
            .cnt_i   (cnt),
            .hi0_i   (hi0),
            .hi1_i   (hi1),
            .line_o  (line_o[ch])
        );
    end

    assign busy_o = busy;

    // R3: all channels share one phase, so at a slot start they are all active
    a_r3_lockstep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy && slot == '0 && cnt == '0) |-> (line_o == {NCH{~pol}}));
endmodule

// File: tb/dshot_quad_tx_tb_top.sv
`timescale 1ns/1ps
module dshot_quad_tx_tb_top;
    localparam int NCH     = 4;
    localparam int PW      = 16;
    localparam int MIN_P   = 4;
    localparam int MAX_P   = 125_000_000 / 150_000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bidir = 1'b0;
    logic [PW-1:0]   period = 16'd8;
    logic            load = 1'b0;
    logic            force_in = 1'b0;
    logic [NCH*16-1:0] cmd = '0;
    logic            busy;
    logic [NCH-1:0]  line;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    dshot_quad_tx dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .bidir_i  (bidir),
        .period_i (period),
        .load_i   (load),
        .force_i  (force_in),
        .cmd_i    (cmd),
        .busy_o   (busy),
        .line_o   (line)
    );

    function automatic logic [15:0] exp_frame(input logic [15:0] c, input logic bd);
        logic [11:0] up;
        logic [3:0]  cs;
        up = {c[10:0], c[15]};
        cs = up[3:0] ^ up[7:4] ^ up[11:8];
        if (bd) cs = ~cs;
        return {up, cs};
    endfunction

    function automatic int clampp(input int p);
        if (p < MIN_P) return MIN_P;
        if (p > MAX_P) return MAX_P;
        return p;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mode 0: plain load, 1: refused load mid frame, 2: forced abort of a junk frame
    task automatic run_frame(input logic [NCH*16-1:0] cmds, input logic bd,
                             input int p_in, input int mode);
        int p, h0, h1, slot_err[NCH], busy_err, ncyc;
        int hc[NCH][20];
        logic [15:0] fr[NCH];
        p  = clampp(p_in);
        h0 = (p * 379) / 1024;
        h1 = (p * 767) / 1024;
        for (int c = 0; c < NCH; c++) begin
            fr[c] = exp_frame(cmds[c*16 +: 16], bd);
            slot_err[c] = 0;
            for (int s = 0; s < 20; s++) hc[c][s] = 0;
        end
        busy_err = 0;
        ncyc = 20 * p;
        if (mode == 2) begin
            @(negedge clk);
            cmd = ~cmds; bidir = ~bd; period = PW'(p_in + 3); load = 1'b1;
            @(negedge clk);
            load = 1'b0;
            for (int k = 0; k < 3 * p + 1; k++) @(negedge clk);
        end
        @(negedge clk);
        cmd = cmds; bidir = bd; period = PW'(p_in); load = 1'b1; force_in = (mode == 2);
        @(negedge clk);
        load = 1'b0; force_in = 1'b0;
        for (int cyc = 0; cyc < ncyc; cyc++) begin
            if (busy !== 1'b1) busy_err++;
            for (int c = 0; c < NCH; c++) begin
                if ((line[c] ^ bd) === 1'b1) hc[c][cyc / p]++;
            end
            if (mode == 1 && cyc == 5 * p + 2) begin
                cmd = ~cmds; bidir = ~bd; period = PW'(p_in + 5); load = 1'b1;
            end
            if (mode == 1 && cyc == 5 * p + 3) begin
                load = 1'b0;
            end
            @(negedge clk);
        end
        // R3, R4, R1, R2: slot-by-slot active time; R5 tail slots zero
        for (int c = 0; c < NCH; c++) begin
            for (int s = 0; s < 20; s++) begin
                int e;
                e = (s < 16) ? (fr[c][15 - s] ? h1 : h0) : 0;
                if (hc[c][s] != e) slot_err[c]++;
            end
            chk(slot_err[c] == 0,
                (mode == 1) ? "R8 slot widths after refused load" :
                (mode == 2) ? "R9 slot widths after forced restart" :
                              "R1/R2/R3/R4 slot widths",
                slot_err[c], 0);
        end
        chk(busy_err == 0, "R5 busy during frame", busy_err, 0);
        // R5: busy drops after 20*P cycles; R7: idle at inactive level
        chk(busy === 1'b0, "R5 busy end", int'(busy), 0);
        for (int k = 0; k < 2; k++) begin
            chk(line === {NCH{bd}}, "R7 idle level", int'(line), int'({NCH{bd}}));
            @(negedge clk);
        end
    endtask

    initial begin
        logic [15:0] pats[8];
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h87FF; pats[3] = 16'h7800;
        pats[4] = 16'h0555; pats[5] = 16'h82AA; pats[6] = 16'h0030; pats[7] = 16'h8001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "reset busy", int'(busy), 0);
        chk(line === '0, "reset line", int'(line), 0);
        // R1..R5, R7 sweep; pattern 3 only has bits 14..11 set (R1 ignored bits)
        for (int pi = 0; pi < 3; pi++) begin
            int pv;
            pv = (pi == 0) ? 8 : (pi == 1) ? 20 : 37;
            for (int b = 0; b < 2; b++) begin
                for (int r = 0; r < 2; r++) begin
                    logic [NCH*16-1:0] cv;
                    for (int c = 0; c < NCH; c++) cv[c*16 +: 16] = pats[(r * 4 + c + pi) % 8];
                    run_frame(cv, logic'(b), pv, 0);
                end
            end
        end
        // R6: clamp below and above range
        run_frame({pats[1], pats[2], pats[5], pats[6]}, 1'b0, 1, 0);
        run_frame({pats[4], pats[7], pats[0], pats[1]}, 1'b1, 2000, 0);
        // R8, R10: refused mid-frame load with changed mode and period
        run_frame({pats[5], pats[4], pats[2], pats[7]}, 1'b0, 12, 1);
        run_frame({pats[6], pats[1], pats[3], pats[0]}, 1'b1, 12, 1);
        // R9: forced abort of a frame in flight
        run_frame({pats[2], pats[3], pats[4], pats[5]}, 1'b1, 10, 2);
        run_frame({pats[7], pats[6], pats[1], pats[0]}, 1'b0, 16, 2);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule